// File: doc/BRIEF.md
# Sharer-Group Directory Request Arbiter

This block sits between a set of processors and the directory kept in a shared second-level cache. Each processor belongs to one fixed sharer group, and the members of a group need not have neighbouring indices. Each cycle, the block merges the requests inside each group down to one representative. It then chooses up to one representative per cache port and issues registered grants. Each grant carries the winning processor index, its group, the read/write type and the address tag.

Candidates are ordered on five keys, strongest first. A request that has waited too long comes first, and among such requests the oldest wins. Next come request priority, then independent requests ahead of requests that carried a dependency flag, then the group with more pending requests. Lower group number and lower processor index settle any remaining tie. A request flagged as dependent on another processor's pending request stays ineligible until that request has been granted. A requester holds its request until it sees its one-cycle acknowledge.

Top module: `sga_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released with no requests, every grant valid bit and every acknowledge bit is 0.
- R2: At most one request per sharer group is granted in a cycle, so no two ports carry the same group. The number of acknowledge bits set equals the number of grant ports that are valid.
- R3: A valid grant on a port carries the winner's processor index, its group ID (processor i maps to group i mod 4 by default), its write bit (1 = write, 0 = read) and its tag. The acknowledge bit of that processor is set in the same cycle.
- R4: A pending request with a higher priority value (larger number means more urgent) is granted before one with a lower value.
- R5: A request whose dependency flag is set, and whose named target processor still has a pending request, is not granted. It becomes eligible in the cycle after the target's request is withdrawn.
- R6: At equal priority, a request with its dependency flag clear is chosen before one with the flag set.
- R7: At equal priority and dependency flag, the group with more pending requests is served first.
- R8: Any remaining tie goes to the lower group ID across groups, and to the lower processor index within a group.
- R9: Port 0 receives the best candidate and port 1 the next best from a different group. A higher port is never valid while a lower port is idle.
- R10: A request left pending for 1000 cycles is granted within the following two cycles, ahead of every request of higher priority.
- R11: A grant appears only for a processor whose request was valid before the grant edge. A processor is not granted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_PROC | Request pending, one bit per processor |
| req_write | input | N_PROC | 1 = write, 0 = read |
| req_tag | input | N_PROC*TAG_W | Target block tag per processor |
| req_prio | input | N_PROC*PRIO_W | Priority per processor, larger is more urgent |
| req_dep | input | N_PROC | Request depends on another processor's request |
| req_dep_on | input | N_PROC*PIDX_W | Processor index the request depends on |
| req_ack | output | N_PROC | One-cycle acknowledge to the granted processors |
| gnt_valid | output | N_PORT | Grant valid per cache port |
| gnt_proc | output | N_PORT*PIDX_W | Granted processor index per port |
| gnt_group | output | N_PORT*GID_W | Granted group ID per port |
| gnt_write | output | N_PORT | Operation type per port |
| gnt_tag | output | N_PORT*TAG_W | Tag per port |

## Verification
Starvation is the hardest state to reach from the ports. A low-priority request has to lose for a thousand straight cycles while both ports stay busy with other groups. The stimulus keeps four high-priority requesters in two groups continuously asserted. Because a processor cannot win twice in a row, the two members of each group take turns, and both ports fill every cycle with higher-priority work. The bench then counts cycles until the starved processor is acknowledged and checks that it took port 0.

// File: rtl/sga_pkg.sv
package sga_pkg;
  typedef enum logic {
    SGA_OP_READ  = 1'b0,
    SGA_OP_WRITE = 1'b1
  } sga_op_e;
endpackage

// File: rtl/sga_age_tracker.sv
module sga_age_tracker #(
  parameter int N_PROC       = 8,
  parameter int STARVE_LIMIT = 1000,
  parameter int AGE_W        = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PROC-1:0]       pending,
  input  logic [N_PROC-1:0]       granted,
  output logic [N_PROC*AGE_W-1:0] age,
  output logic [N_PROC-1:0]       starved
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] LIMIT   = AGE_W'(STARVE_LIMIT);

  for (genvar i = 0; i < N_PROC; i++) begin : g_proc
    logic [AGE_W-1:0] age_q, age_d;
    logic             age_en;

    always_comb begin
      age_d = age_q;
      if (!pending[i] || granted[i]) begin
        age_d = '0;
      end else if (age_q != AGE_MAX) begin
        age_d = age_q + 1'b1;
      end
    end

    assign age_en = pending[i] || (age_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q <= '0;
      end else if (age_en) begin
        age_q <= age_d;
      end
    end

    assign age[i*AGE_W +: AGE_W] = age_q;
    assign starved[i]            = pending[i] && (age_q >= LIMIT);
  end
endmodule

// File: rtl/sga_group_merge.sv
module sga_group_merge #(
  parameter int N_PROC  = 8,
  parameter int N_GROUP = 4,
  parameter int GID_W   = 2,
  parameter int PIDX_W  = 3,
  parameter int PRIO_W  = 2,
  parameter int AGE_W   = 10,
  parameter int CNT_W   = 4,
  parameter int KEY_W   = 18,
  parameter logic [N_PROC*GID_W-1:0] GROUP_MAP = '0
) (
  input  logic [N_PROC-1:0]        pending,
  input  logic [N_PROC-1:0]        eligible,
  input  logic [N_PROC*PRIO_W-1:0] prio,
  input  logic [N_PROC-1:0]        dep,
  input  logic [N_PROC*AGE_W-1:0]  age,
  input  logic [N_PROC-1:0]        starved,
  output logic [N_GROUP-1:0]       grp_valid,
  output logic [N_GROUP*KEY_W-1:0] grp_key,
  output logic [N_GROUP*PIDX_W-1:0] grp_proc
);
  logic [CNT_W-1:0] occ [N_GROUP];
  logic [KEY_W-1:0] key [N_PROC];

  // pending count per group
  always_comb begin
    for (int g = 0; g < N_GROUP; g++) begin
      occ[g] = '0;
      for (int i = 0; i < N_PROC; i++) begin
        if (GROUP_MAP[i*GID_W +: GID_W] == GID_W'(g)) begin
          occ[g] = occ[g] + CNT_W'(pending[i]);
        end
      end
    end
  end

  // ordering key per processor: starved, age when starved, prio, independent, occupancy
  for (genvar i = 0; i < N_PROC; i++) begin : g_key
    logic [GID_W-1:0] gid;
    logic [AGE_W-1:0] age_part;
    assign gid      = GROUP_MAP[i*GID_W +: GID_W];
    assign age_part = starved[i] ? age[i*AGE_W +: AGE_W] : '0;
    assign key[i]   = {starved[i], age_part, prio[i*PRIO_W +: PRIO_W], ~dep[i], occ[gid]};
  end

  // best eligible member of each group; ascending scan keeps lower index on ties
  always_comb begin
    for (int g = 0; g < N_GROUP; g++) begin
      logic             found;
      logic [KEY_W-1:0] best;
      logic [PIDX_W-1:0] who;
      found = 1'b0;
      best  = '0;
      who   = '0;
      for (int i = 0; i < N_PROC; i++) begin
        if (eligible[i] && (GROUP_MAP[i*GID_W +: GID_W] == GID_W'(g))) begin
          if (!found || (key[i] > best)) begin
            found = 1'b1;
            best  = key[i];
            who   = PIDX_W'(i);
          end
        end
      end
      grp_valid[g]                   = found;
      grp_key[g*KEY_W +: KEY_W]      = best;
      grp_proc[g*PIDX_W +: PIDX_W]   = who;
    end
  end
endmodule

// File: rtl/sga_port_select.sv
module sga_port_select #(
  parameter int N_GROUP = 4,
  parameter int N_PORT  = 2,
  parameter int GID_W   = 2,
  parameter int KEY_W   = 18
) (
  input  logic [N_GROUP-1:0]       grp_valid,
  input  logic [N_GROUP*KEY_W-1:0] grp_key,
  output logic [N_PORT-1:0]        sel_valid,
  output logic [N_PORT*GID_W-1:0]  sel_grp
);
  always_comb begin
    logic [N_GROUP-1:0] taken;
    taken = '0;
    for (int p = 0; p < N_PORT; p++) begin
      logic             found;
      logic [KEY_W-1:0] best;
      logic [GID_W-1:0] bidx;
      found = 1'b0;
      best  = '0;
      bidx  = '0;
      for (int g = 0; g < N_GROUP; g++) begin
        if (grp_valid[g] && !taken[g]) begin
          if (!found || (grp_key[g*KEY_W +: KEY_W] > best)) begin
            found = 1'b1;
            best  = grp_key[g*KEY_W +: KEY_W];
            bidx  = GID_W'(g);
          end
        end
      end
      sel_valid[p]                 = found;
      sel_grp[p*GID_W +: GID_W]    = bidx;
      if (found) begin
        taken[bidx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sga_arbiter.sv
module sga_arbiter
  import sga_pkg::*;
#(
  parameter int N_PROC       = 8,
  parameter int N_GROUP      = 4,
  parameter int N_PORT       = 2,
  parameter int TAG_W        = 16,
  parameter int PRIO_W       = 2,
  parameter int STARVE_LIMIT = 1000,
  parameter logic [N_PROC*$clog2(N_GROUP)-1:0] GROUP_MAP = 16'hE4E4,
  localparam int PIDX_W      = $clog2(N_PROC),
  localparam int GID_W       = $clog2(N_GROUP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PROC-1:0]         req_valid,
  input  logic [N_PROC-1:0]         req_write,
  input  logic [N_PROC*TAG_W-1:0]   req_tag,
  input  logic [N_PROC*PRIO_W-1:0]  req_prio,
  input  logic [N_PROC-1:0]         req_dep,
  input  logic [N_PROC*PIDX_W-1:0]  req_dep_on,
  output logic [N_PROC-1:0]         req_ack,
  output logic [N_PORT-1:0]         gnt_valid,
  output logic [N_PORT*PIDX_W-1:0]  gnt_proc,
  output logic [N_PORT*GID_W-1:0]   gnt_group,
  output logic [N_PORT-1:0]         gnt_write,
  output logic [N_PORT*TAG_W-1:0]   gnt_tag
);
  localparam int AGE_W = $clog2(STARVE_LIMIT + 1);
  localparam int CNT_W = $clog2(N_PROC + 1);
  localparam int KEY_W = 1 + AGE_W + PRIO_W + 1 + CNT_W;

  logic [N_PROC-1:0]         ack_q;
  logic [N_PROC-1:0]         pending;
  logic [N_PROC-1:0]         eligible;
  logic [N_PROC-1:0]         granted_d;
  logic [N_PROC*AGE_W-1:0]   age;
  logic [N_PROC-1:0]         starved;
  logic [N_GROUP-1:0]        grp_valid;
  logic [N_GROUP*KEY_W-1:0]  grp_key;
  logic [N_GROUP*PIDX_W-1:0] grp_proc;
  logic [N_PORT-1:0]         sel_valid;
  logic [N_PORT*GID_W-1:0]   sel_grp;

  logic [N_PORT-1:0]         gv_d, gv_q;
  logic [N_PORT*PIDX_W-1:0]  gp_d, gp_q;
  logic [N_PORT*GID_W-1:0]   gg_d, gg_q;
  logic [N_PORT-1:0]         gw_d, gw_q;
  logic [N_PORT*TAG_W-1:0]   gt_d, gt_q;

  // a processor acknowledged last cycle is withdrawing and does not compete
  assign pending = req_valid & ~ack_q;

  for (genvar i = 0; i < N_PROC; i++) begin : g_elig
    logic [PIDX_W-1:0] tgt;
    logic              tgt_busy;
    assign tgt      = req_dep_on[i*PIDX_W +: PIDX_W];
    assign tgt_busy = (int'(tgt) < N_PROC) ? pending[tgt] : 1'b0;
    assign eligible[i] = pending[i] && !(req_dep[i] && tgt_busy);
  end

  sga_age_tracker #(
    .N_PROC      (N_PROC),
    .STARVE_LIMIT(STARVE_LIMIT),
    .AGE_W       (AGE_W)
  ) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(pending),
    .granted(granted_d),
    .age    (age),
    .starved(starved)
  );

  sga_group_merge #(
    .N_PROC   (N_PROC),
    .N_GROUP  (N_GROUP),
    .GID_W    (GID_W),
    .PIDX_W   (PIDX_W),
    .PRIO_W   (PRIO_W),
    .AGE_W    (AGE_W),
    .CNT_W    (CNT_W),
    .KEY_W    (KEY_W),
    .GROUP_MAP(GROUP_MAP)
  ) u_merge (
    .pending  (pending),
    .eligible (eligible),
    .prio     (req_prio),
    .dep      (req_dep),
    .age      (age),
    .starved  (starved),
    .grp_valid(grp_valid),
    .grp_key  (grp_key),
    .grp_proc (grp_proc)
  );

  sga_port_select #(
    .N_GROUP(N_GROUP),
    .N_PORT (N_PORT),
    .GID_W  (GID_W),
    .KEY_W  (KEY_W)
  ) u_sel (
    .grp_valid(grp_valid),
    .grp_key  (grp_key),
    .sel_valid(sel_valid),
    .sel_grp  (sel_grp)
  );

  // next-state for the grant ports
  always_comb begin
    gv_d      = '0;
    gp_d      = '0;
    gg_d      = '0;
    gw_d      = '0;
    gt_d      = '0;
    granted_d = '0;
    for (int p = 0; p < N_PORT; p++) begin
      logic [GID_W-1:0]  g;
      logic [PIDX_W-1:0] w;
      g = sel_grp[p*GID_W +: GID_W];
      w = grp_proc[g*PIDX_W +: PIDX_W];
      if (sel_valid[p]) begin
        gv_d[p]                  = 1'b1;
        gp_d[p*PIDX_W +: PIDX_W] = w;
        gg_d[p*GID_W +: GID_W]   = g;
        gw_d[p]                  = (sga_op_e'(req_write[w]) == SGA_OP_WRITE);
        gt_d[p*TAG_W +: TAG_W]   = req_tag[w*TAG_W +: TAG_W];
        granted_d[w]             = 1'b1;
      end
    end
  end

  // valid/ack registers update every cycle; payload only when a port grants
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q  <= '0;
      ack_q <= '0;
    end else begin
      gv_q  <= gv_d;
      ack_q <= granted_d;
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gp_q[p*PIDX_W +: PIDX_W] <= '0;
        gg_q[p*GID_W +: GID_W]   <= '0;
        gw_q[p]                  <= 1'b0;
        gt_q[p*TAG_W +: TAG_W]   <= '0;
      end else if (gv_d[p]) begin
        gp_q[p*PIDX_W +: PIDX_W] <= gp_d[p*PIDX_W +: PIDX_W];
        gg_q[p*GID_W +: GID_W]   <= gg_d[p*GID_W +: GID_W];
        gw_q[p]                  <= gw_d[p];
        gt_q[p*TAG_W +: TAG_W]   <= gt_d[p*TAG_W +: TAG_W];
      end
    end
  end

  assign req_ack   = ack_q;
  assign gnt_valid = gv_q;
  assign gnt_proc  = gp_q;
  assign gnt_group = gg_q;
  assign gnt_write = gw_q;
  assign gnt_tag   = gt_q;
endmodule

// File: rtl/sga_arbiter_chk.sv
module sga_arbiter_chk #(
  parameter int N_PROC  = 8,
  parameter int N_GROUP = 4,
  parameter int N_PORT  = 2,
  parameter int PIDX_W  = 3,
  parameter int GID_W   = 2,
  parameter logic [N_PROC*GID_W-1:0] GROUP_MAP = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_PROC-1:0]        req_valid,
  input logic [N_PROC-1:0]        req_dep,
  input logic [N_PROC*PIDX_W-1:0] req_dep_on,
  input logic [N_PROC-1:0]        req_ack,
  input logic [N_PORT-1:0]        gnt_valid,
  input logic [N_PORT*PIDX_W-1:0] gnt_proc,
  input logic [N_PORT*GID_W-1:0]  gnt_group
);
  logic [N_PROC-1:0]        prev_valid;
  logic [N_PROC-1:0]        prev_pending;
  logic [N_PROC-1:0]        prev_dep;
  logic [N_PROC*PIDX_W-1:0] prev_dep_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid   <= '0;
      prev_pending <= '0;
      prev_dep     <= '0;
      prev_dep_on  <= '0;
    end else begin
      prev_valid   <= req_valid;
      prev_pending <= req_valid & ~req_ack;
      prev_dep     <= req_dep;
      prev_dep_on  <= req_dep_on;
    end
  end

  a_r2_ack_matches_ports: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ack) == $countones(gnt_valid));

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    logic [PIDX_W-1:0] w;
    logic [PIDX_W-1:0] t;
    assign w = gnt_proc[p*PIDX_W +: PIDX_W];
    assign t = prev_dep_on[w*PIDX_W +: PIDX_W];

    a_r11_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[p] |-> prev_valid[w]);

    a_r5_dependency_respected: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[p] |-> !(prev_dep[w] && prev_pending[t]));

    a_r3_group_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[p] |-> (gnt_group[p*GID_W +: GID_W] == GROUP_MAP[w*GID_W +: GID_W]));

    a_r3_ack_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[p] |-> req_ack[w]);

    if (p > 0) begin : g_order
      a_r9_ports_fill_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid[p] |-> gnt_valid[p-1]);
    end

    for (genvar q = p + 1; q < N_PORT; q++) begin : g_pair
      a_r2_distinct_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[p] && gnt_valid[q]) |->
          (gnt_group[p*GID_W +: GID_W] != gnt_group[q*GID_W +: GID_W]));
    end
  end

  for (genvar i = 0; i < N_PROC; i++) begin : g_proc
    a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack[i] |=> !req_ack[i]);
  end
endmodule

bind sga_arbiter sga_arbiter_chk #(
  .N_PROC   (N_PROC),
  .N_GROUP  (N_GROUP),
  .N_PORT   (N_PORT),
  .PIDX_W   (PIDX_W),
  .GID_W    (GID_W),
  .GROUP_MAP(GROUP_MAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_dep   (req_dep),
  .req_dep_on(req_dep_on),
  .req_ack   (req_ack),
  .gnt_valid (gnt_valid),
  .gnt_proc  (gnt_proc),
  .gnt_group (gnt_group)
);

// File: tb/sga_arbiter_tb.sv
module sga_arbiter_tb;
  localparam int N  = 8;
  localparam int P  = 2;
  localparam int TW = 16;
  localparam int PW = 2;
  localparam int IW = 3;
  localparam int GW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid, req_write, req_dep, req_ack;
  logic [N*TW-1:0] req_tag;
  logic [N*PW-1:0] req_prio;
  logic [N*IW-1:0] req_dep_on;
  logic [P-1:0]    gnt_valid, gnt_write;
  logic [P*IW-1:0] gnt_proc;
  logic [P*GW-1:0] gnt_group;
  logic [P*TW-1:0] gnt_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sga_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
    .req_prio(req_prio), .req_dep(req_dep), .req_dep_on(req_dep_on),
    .req_ack(req_ack), .gnt_valid(gnt_valid), .gnt_proc(gnt_proc),
    .gnt_group(gnt_group), .gnt_write(gnt_write), .gnt_tag(gnt_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_port(input int p, input int proc, input string req);
    chk(gnt_valid[p] == 1'b1, {req, " port valid"}, int'(gnt_valid[p]), 1);
    chk(int'(gnt_proc[p*IW +: IW]) == proc, {req, " port proc"},
        int'(gnt_proc[p*IW +: IW]), proc);
  endtask

  task automatic expect_idle(input int p, input string req);
    chk(gnt_valid[p] == 1'b0, {req, " port idle"}, int'(gnt_valid[p]), 0);
  endtask

  task automatic clear_all();
    req_valid = '0; req_write = '0; req_dep = '0;
    req_tag = '0; req_prio = '0; req_dep_on = '0;
  endtask

  task automatic set_req(input int i, input bit wr, input int tag, input int prio,
                         input bit dep, input int dep_on);
    req_valid[i]           = 1'b1;
    req_write[i]           = wr;
    req_tag[i*TW +: TW]    = TW'(tag);
    req_prio[i*PW +: PW]   = PW'(prio);
    req_dep[i]             = dep;
    req_dep_on[i*IW +: IW] = IW'(dep_on);
  endtask

  task automatic settle();
    clear_all();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(gnt_valid == '0, "R1 grants in reset", int'(gnt_valid), 0);
    chk(req_ack == '0, "R1 acks in reset", int'(req_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_valid == '0, "R1 grants after release", int'(gnt_valid), 0);
    chk(req_ack == '0, "R11 no request no ack", int'(req_ack), 0);
  endtask

  task automatic t_single();
    set_req(5, 1'b1, 16'hBEEF, 1, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 5, "R3 single");
    chk(int'(gnt_group[0 +: GW]) == 1, "R3 group", int'(gnt_group[0 +: GW]), 1);
    chk(gnt_write[0] == 1'b1, "R3 write", int'(gnt_write[0]), 1);
    chk(gnt_tag[0 +: TW] == 16'hBEEF, "R3 tag", int'(gnt_tag[0 +: TW]), 16'hBEEF);
    chk(req_ack == 8'h20, "R3 ack", int'(req_ack), 32);
    expect_idle(1, "R9 single");
    settle();
  endtask

  task automatic t_merge();
    set_req(1, 1'b0, 16'h11, 0, 1'b0, 0);
    set_req(5, 1'b0, 16'h55, 0, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 1, "R8 lower index in group");
    expect_idle(1, "R2 one per group");
    req_valid[1] = 1'b0;
    @(negedge clk);
    expect_port(0, 5, "R2 second member later");
    chk(gnt_write[0] == 1'b0, "R3 read type", int'(gnt_write[0]), 0);
    settle();
  endtask

  task automatic t_prio();
    set_req(2, 1'b0, 2, 1, 1'b0, 0);
    set_req(3, 1'b0, 3, 3, 1'b0, 0);
    set_req(0, 1'b0, 0, 2, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 3, "R4 highest prio");
    expect_port(1, 0, "R9 second best");
    settle();
  endtask

  task automatic t_dep();
    set_req(1, 1'b0, 1, 0, 1'b0, 0);
    set_req(6, 1'b1, 6, 3, 1'b1, 1);
    @(negedge clk);
    expect_port(0, 1, "R5 target first");
    expect_idle(1, "R5 dependent blocked");
    req_valid[1] = 1'b0;
    @(negedge clk);
    expect_port(0, 6, "R5 dependent released");
    settle();
  endtask

  task automatic t_depflag();
    set_req(0, 1'b0, 0, 2, 1'b1, 7);
    set_req(1, 1'b0, 1, 2, 1'b0, 0);
    set_req(2, 1'b0, 2, 2, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 1, "R6 independent first");
    expect_port(1, 2, "R6 independent second");
    settle();
  endtask

  task automatic t_occupancy();
    set_req(0, 1'b0, 0, 0, 1'b0, 0);
    set_req(2, 1'b0, 2, 0, 1'b0, 0);
    set_req(3, 1'b0, 3, 0, 1'b0, 0);
    set_req(7, 1'b0, 7, 0, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 3, "R7 fuller group first");
    expect_port(1, 0, "R8 lower group on tie");
    settle();
  endtask

  task automatic t_no_repeat();
    set_req(4, 1'b0, 4, 1, 1'b0, 0);
    @(negedge clk);
    expect_port(0, 4, "R11 first grant");
    @(negedge clk);
    expect_idle(0, "R11 no back-to-back");
    chk(req_ack == '0, "R11 ack drops", int'(req_ack), 0);
    @(negedge clk);
    expect_port(0, 4, "R11 regrant");
    settle();
  endtask

  task automatic t_starve();
    int n;
    bit seen;
    set_req(0, 1'b0, 0, 3, 1'b0, 0);
    set_req(4, 1'b0, 4, 3, 1'b0, 0);
    set_req(1, 1'b0, 1, 3, 1'b0, 0);
    set_req(5, 1'b0, 5, 3, 1'b0, 0);
    set_req(2, 1'b1, 16'h2222, 0, 1'b0, 0);
    n = 0;
    seen = 1'b0;
    while (!seen && n < 1100) begin
      @(negedge clk);
      n++;
      if (req_ack[2]) begin
        seen = 1'b1;
        expect_port(0, 2, "R10 starved on port 0");
      end else if (n == 500) begin
        chk(gnt_valid == 2'b11, "R10 ports busy meanwhile", int'(gnt_valid), 3);
      end
    end
    chk(seen && n >= 1000 && n <= 1002, "R10 starvation latency", n, 1001);
    settle();
  endtask

  initial begin
    clear_all();
    rst_n = 1'b0;
    t_reset();
    t_single();
    t_merge();
    t_prio();
    t_dep();
    t_depflag();
    t_occupancy();
    t_no_repeat();
    t_starve();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule